// File: doc/BRIEF.md
# Vertical Microcode Opcode Sequencer

This block is the control half of a datapath driven by tightly packed vertical microcode. Each microword holds a four-bit opcode and a payload. A small opcode table expands the opcode into a vector of register clock enables and a two-bit test select. When the enable vector is zero, the word is a branch: the payload carries a target address and the selected condition decides whether to jump. When any enable is set, the word is a constant step: the payload carries a single multiplexer select shared by every datapath multiplexer, plus a constant for the datapath. A constant step never branches.

The sequencer is a microprogram counter with two named states. SEQ_IDLE is entered on reset. It holds the address at 0 and keeps every output other than the address quiet. The transition SEQ_IDLE to SEQ_RUN happens on the first clock edge without reset. In SEQ_RUN the sequencer stays in SEQ_RUN and, on each edge, either loads the branch target or increments. It goes back to SEQ_IDLE only through reset. The microprogram and the opcode table are parameters.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is high, and for the first cycle after it falls, the address is 0 and the enables, mux select and constant are all 0. The word at address 0 executes in the following cycle.
- R2: In SEQ_RUN the enable output equals the clock field of the table entry for the current opcode. The default table gives 0 for opcodes 0 to 3 and the opcode value itself for opcodes 4 to 15, with bit i enabling register i.
- R3: A microword is {opcode[11:8], payload[7:0]}. In constant form the shared mux select is payload[7:6] and the constant is payload[5:0].
- R4: In branch form (decoded enable vector zero) the mux select and constant outputs are 0, and the target is payload[3:0].
- R5: Test select 0 never branches, 1 tests cond_i[0], 2 tests cond_i[1], and 3 always branches. The default table gives test = opcode[1:0].
- R6: A branch-form word whose selected condition is true loads the target on the next edge.
- R7: Otherwise the address increments, wrapping from 15 to 0.
- R8: In constant form the table's test field is ignored: the address always increments, whatever the conditions and even when the table entry holds a nonzero test.
- R9: Several enables may be high in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 2 | Datapath condition flags |
| reg_en_o | output | 4 | Register clock enables |
| mux_sel_o | output | 2 | Select shared by all datapath multiplexers |
| const_o | output | 6 | Constant to the datapath |
| addr_o | output | 4 | Microprogram counter |

## Verification
The bench builds the block with its default widths: a 4-bit address, a 2-bit shared select, a 6-bit constant and the default opcode table. It overrides only the microprogram, with a 16-word program of its own. That program places both conditional tests, the never and always tests, a constant word whose table test would mean always, and the all-ones enable opcode where varying condition patterns reach them. It also runs the path to the last address, so the wrap to 0 occurs. A reset in the middle of the run repeats the boot cycle from a non-zero address.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W   = 4;
    localparam int EN_W   = 4;
    localparam int TEST_W = 2;
    localparam int OPS    = 2 ** OP_W;
    localparam int DEC_W  = EN_W + TEST_W;

    localparam int DEF_ADDR_W = 4;
    localparam int DEF_PAY_W  = 8;
    localparam int DEF_WORD_W = OP_W + DEF_PAY_W;
    localparam int DEF_DEPTH  = 2 ** DEF_ADDR_W;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic [EN_W-1:0]   en;
        logic [TEST_W-1:0] test;
    } dec_entry_t;

    function automatic logic [OPS*DEC_W-1:0] build_decode();
        logic [OPS*DEC_W-1:0] tbl;
        dec_entry_t           ent;
        tbl = '0;
        for (int op = 0; op < OPS; op++) begin
            ent.en   = (op < 4) ? '0 : EN_W'(op);
            ent.test = TEST_W'(op);
            tbl[op*DEC_W +: DEC_W] = ent;
        end
        return tbl;
    endfunction

    function automatic logic [DEF_DEPTH*DEF_WORD_W-1:0] build_program();
        logic [DEF_DEPTH*DEF_WORD_W-1:0] prg;
        prg = '0;
        for (int i = 0; i < DEF_DEPTH - 1; i++) begin
            prg[i*DEF_WORD_W +: DEF_WORD_W] = {OP_W'(4 + (i % 12)), DEF_PAY_W'(i * 37)};
        end
        prg[(DEF_DEPTH-1)*DEF_WORD_W +: DEF_WORD_W] = {OP_W'(3), DEF_PAY_W'(0)};
        return prg;
    endfunction

    localparam logic [OPS*DEC_W-1:0]               DEF_DECODE = build_decode();
    localparam logic [DEF_DEPTH*DEF_WORD_W-1:0]    DEF_UCODE  = build_program();

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 12,
    parameter     UCODE  = useq_pkg::DEF_UCODE
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [WORD_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign rom[g] = UCODE[g*WORD_W +: WORD_W];
    end

    assign word_o = rom[addr_i];
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MUX_W   = 2,
    parameter int CONST_W = 6,
    parameter     DECODE  = useq_pkg::DEF_DECODE
) (
    input  logic [OP_W+((ADDR_W > MUX_W+CONST_W) ? ADDR_W : MUX_W+CONST_W)-1:0] word_i,
    output logic [EN_W-1:0]    en_o,
    output logic [TEST_W-1:0]  test_o,
    output logic               branch_o,
    output logic [MUX_W-1:0]   mux_o,
    output logic [CONST_W-1:0] const_o,
    output logic [ADDR_W-1:0]  target_o
);
    localparam int DATA_W = MUX_W + CONST_W;
    localparam int PAY_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int WORD_W = OP_W + PAY_W;

    logic [OP_W-1:0]   opcode;
    logic [PAY_W-1:0]  payload;
    dec_entry_t        entry;
    logic [DATA_W-1:0] data_f;

    assign opcode  = word_i[WORD_W-1 -: OP_W];
    assign payload = word_i[PAY_W-1:0];
    assign entry   = dec_entry_t'(DECODE[opcode*DEC_W +: DEC_W]);
    assign data_f  = payload[DATA_W-1:0];

    always_comb begin
        en_o     = entry.en;
        branch_o = (entry.en == '0);
        target_o = payload[ADDR_W-1:0];
        if (branch_o) begin
            test_o  = entry.test;
            mux_o   = '0;
            const_o = '0;
        end else begin
            test_o  = '0;
            mux_o   = data_f[DATA_W-1 -: MUX_W];
            const_o = data_f[CONST_W-1:0];
        end
    end
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
    import useq_pkg::*;
#(
    parameter int COND_W = (2 ** TEST_W) - 2
) (
    input  logic [TEST_W-1:0] test_i,
    input  logic [COND_W-1:0] cond_i,
    output logic              take_o
);
    localparam int SRC_N = 2 ** TEST_W;

    logic [SRC_N-1:0] cand;

    assign cand[0]       = 1'b0;
    assign cand[SRC_N-1] = 1'b1;
    for (genvar k = 0; k < COND_W; k++) begin : g_cond
        assign cand[k+1] = cond_i[k];
    end

    assign take_o = cand[test_i];
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              run_o,
    output logic [ADDR_W-1:0] upc_o
);
    seq_state_e        st_q, st_nx;
    logic [ADDR_W-1:0] upc_q, upc_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            upc_q <= '0;
        end else begin
            st_q  <= st_nx;
            upc_q <= upc_nx;
        end
    end

    always_comb begin
        st_nx  = st_q;
        upc_nx = upc_q;
        unique case (st_q)
            SEQ_IDLE: begin
                st_nx = SEQ_RUN;
            end
            SEQ_RUN: begin
                st_nx  = SEQ_RUN;
                upc_nx = take_i ? target_i : upc_q + 1'b1;
            end
            default: st_nx = SEQ_IDLE;
        endcase
    end

    assign run_o = (st_q == SEQ_RUN);
    assign upc_o = upc_q;

    // R6: a taken branch lands on its target
    a_r6_branch_load: assert property (@(posedge clk) disable iff (rst)
        (run_o && take_i) |=> (upc_o == $past(target_i)));

    // R7: a step without a taken branch increments
    a_r7_increment: assert property (@(posedge clk) disable iff (rst)
        (run_o && !take_i) |=> (upc_o == ADDR_W'($past(upc_o) + 1'b1)));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int MUX_W   = 2,
    parameter int CONST_W = 6,
    parameter int COND_W  = (2 ** TEST_W) - 2,
    parameter     UCODE   = useq_pkg::DEF_UCODE,
    parameter     DECODE  = useq_pkg::DEF_DECODE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COND_W-1:0]  cond_i,
    output logic [EN_W-1:0]    reg_en_o,
    output logic [MUX_W-1:0]   mux_sel_o,
    output logic [CONST_W-1:0] const_o,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam int DATA_W = MUX_W + CONST_W;
    localparam int PAY_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int WORD_W = OP_W + PAY_W;

    logic [WORD_W-1:0]  word;
    logic [EN_W-1:0]    dec_en;
    logic [TEST_W-1:0]  dec_test;
    logic               dec_branch;
    logic [MUX_W-1:0]   dec_mux;
    logic [CONST_W-1:0] dec_const;
    logic [ADDR_W-1:0]  dec_target;
    logic               take;
    logic               run;
    logic [ADDR_W-1:0]  upc;

    useq_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .UCODE  (UCODE)
    ) store_i (
        .addr_i (upc),
        .word_o (word)
    );

    useq_decode #(
        .ADDR_W  (ADDR_W),
        .MUX_W   (MUX_W),
        .CONST_W (CONST_W),
        .DECODE  (DECODE)
    ) decode_i (
        .word_i   (word),
        .en_o     (dec_en),
        .test_o   (dec_test),
        .branch_o (dec_branch),
        .mux_o    (dec_mux),
        .const_o  (dec_const),
        .target_o (dec_target)
    );

    useq_cond_sel #(
        .COND_W (COND_W)
    ) cond_sel_i (
        .test_i (dec_test),
        .cond_i (cond_i),
        .take_o (take)
    );

    useq_ctrl #(
        .ADDR_W (ADDR_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .take_i   (take),
        .target_i (dec_target),
        .run_o    (run),
        .upc_o    (upc)
    );

    always_comb begin
        if (run) begin
            reg_en_o  = dec_en;
            mux_sel_o = dec_mux;
            const_o   = dec_const;
        end else begin
            reg_en_o  = '0;
            mux_sel_o = '0;
            const_o   = '0;
        end
        addr_o = upc;
    end

    // R1: the cycle after reset is quiet and at address 0
    a_r1_boot_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (addr_o == '0 && reg_en_o == '0 && mux_sel_o == '0 && const_o == '0));

    // R4: branch-form words drive no mux select or constant
    a_r4_branch_quiet: assert property (@(posedge clk) disable iff (rst)
        (dec_branch) |-> (mux_sel_o == '0 && const_o == '0));

    // R8: a constant-form step never branches
    a_r8_const_steps: assert property (@(posedge clk) disable iff (rst)
        (run && reg_en_o != '0) |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

    // R5: test 0 never branches, the all-ones test always does
    a_r5_test_ends: assert property (@(posedge clk) disable iff (rst)
        ((dec_test == '0) |-> !take) and ((dec_test == '1) |-> take));
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;

    localparam int AW = 4;
    localparam int WW = 12;
    localparam int N  = 16;

    typedef struct {
        logic [3:0] en;
        logic [1:0] mux;
        logic [5:0] cval;
        logic [3:0] addr;
        string      out_tag;
        string      addr_tag;
    } exp_t;

    function automatic logic [N*WW-1:0] make_prog();
        logic [WW-1:0] w [N];
        logic [N*WW-1:0] p;
        w[0]  = 12'h445; w[1]  = 12'hFFF; w[2]  = 12'h1A6; w[3]  = 12'h791;
        w[4]  = 12'h259; w[5]  = 12'h03C; w[6]  = 12'h5AA; w[7]  = 12'h3E0;
        w[8]  = 12'h912; w[9]  = 12'hA01; w[10] = 12'hC50; w[11] = 12'h6C7;
        w[12] = 12'h83F; w[13] = 12'hB80; w[14] = 12'hD24; w[15] = 12'hE9B;
        p = '0;
        for (int i = 0; i < N; i++) p[i*WW +: WW] = w[i];
        return p;
    endfunction

    localparam logic [N*WW-1:0] PROG = make_prog();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond = 2'b00;
    logic [3:0] reg_en;
    logic [1:0] mux_sel;
    logic [5:0] cval;
    logic [3:0] addr;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    exp_t q[$];

    bit         m_run = 1'b0;
    logic [3:0] m_upc = '0;
    string      m_addr_tag = "R1";

    always #2.5 clk = ~clk;

    useq_sequencer #(.UCODE(PROG)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cond_i    (cond),
        .reg_en_o  (reg_en),
        .mux_sel_o (mux_sel),
        .const_o   (cval),
        .addr_o    (addr)
    );

    task automatic step(input logic r, input logic [1:0] c);
        exp_t       e;
        logic [11:0] w;
        logic [3:0] op, en;
        logic [7:0] pay;
        logic       take;
        @(negedge clk);
        rst  = r;
        cond = c;
        w   = PROG[m_upc*WW +: WW];
        op  = w[11:8];
        pay = w[7:0];
        en  = (op < 4) ? 4'h0 : op;
        e.addr     = m_upc;
        e.addr_tag = m_addr_tag;
        if (!m_run) begin
            e.en = '0; e.mux = '0; e.cval = '0; e.out_tag = "R1";
        end else if (en == 0) begin
            e.en = '0; e.mux = '0; e.cval = '0; e.out_tag = "R4";
        end else begin
            e.en = en; e.mux = pay[7:6]; e.cval = pay[5:0];
            e.out_tag = ($countones(en) > 1) ? "R9" : "R3";
        end
        q.push_back(e);
        if (r) begin
            m_run = 1'b0; m_upc = '0; m_addr_tag = "R1";
        end else if (!m_run) begin
            m_run = 1'b1; m_addr_tag = "R1";
        end else if (en == 0) begin
            case (op[1:0])
                2'd0:    take = 1'b0;
                2'd1:    take = c[0];
                2'd2:    take = c[1];
                default: take = 1'b1;
            endcase
            m_addr_tag = take ? "R6" : "R5";
            m_upc = take ? pay[3:0] : m_upc + 1'b1;
        end else begin
            m_addr_tag = (op[1:0] != 0) ? "R8" : "R7";
            m_upc = m_upc + 1'b1;
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            vectors++;
            if (addr !== e.addr) begin
                fails++;
                $display("FAIL %s addr actual %0d expected %0d", e.addr_tag, addr, e.addr);
            end
            if (reg_en !== e.en) begin
                fails++;
                $display("FAIL %s reg_en actual %b expected %b",
                         (e.out_tag == "R1") ? "R1" : "R2", reg_en, e.en);
            end
            if (mux_sel !== e.mux || cval !== e.cval) begin
                fails++;
                $display("FAIL %s mux/const actual %0d/%0d expected %0d/%0d",
                         e.out_tag, mux_sel, cval, e.mux, e.cval);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00);      // R1 reset
        for (int i = 0; i < 160; i++) step(1'b0, 2'(i ^ (i >> 2) ^ (i >> 4)));
        for (int i = 0; i < 2; i++) step(1'b1, 2'b11);      // R1 mid-run reset
        for (int i = 0; i < 40; i++) step(1'b0, 2'b10);     // cond1 path, wrap R7
        for (int i = 0; i < 40; i++) step(1'b0, 2'b01);     // cond0 loop R6
        for (int i = 0; i < 40; i++) step(1'b0, 2'b00);     // R5 untaken
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule